// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for the instruction sitting in the execute stage of a five-stage in-order integer pipeline, where each of its two ALU operands should come from. The candidates are the register file read, the result held in the execute/memory pipeline register, and the result held in the memory/writeback pipeline register. The block compares the two source register numbers of the execute-stage instruction with the destination numbers of both older instructions. It then drives a two-bit select per operand and the selected operand value, so that a dependent instruction gets a result that is still in flight without waiting for writeback.

Reads happen in the decode stage and all writes happen in the final stage, so only read-after-write dependences can arise. Write-after-read and write-after-write orderings never need handling. Register zero is hardwired to zero and is never bypassed. When both older stages target the same source register, the younger one (execute/memory) supplies the value.

A second path serves the memory stage. When a store reaches memory directly behind a load whose destination is the store's data register, the loaded word is taken from the memory/writeback register in place of the stale store data. The block is purely combinational. Stall generation, branch resolution and the register file lie outside it.

Top module: `fwd_unit`

## Requirements
- R1: When neither older stage is a valid producer of a source register, that operand's select is 2'b00 and the operand equals the register file value.
- R2: When the execute/memory stage has its write enable set and a nonzero destination equal to a source register, that operand's select is 2'b10 and the operand equals the execute/memory result.
- R3: When only the memory/writeback stage has its write enable set and a nonzero destination equal to a source register, that operand's select is 2'b01 and the operand equals the memory/writeback result.
- R4: When both stages match the same source register, the execute/memory stage wins (select 2'b10).
- R5: A destination of register 0 is never forwarded, whatever the write enables say.
- R6: A stage whose write enable is clear is never a forwarding candidate, even if its destination matches.
- R7: The two operands are resolved independently, so each may take a different source in the same cycle.
- R8: When the memory stage holds a store, the memory/writeback stage holds a load with write enable set, and the load's nonzero destination equals the store's data register, the store data output equals the loaded value and the bypass flag is 1.
- R9: In every other case the store data output equals the store data from the execute/memory register, and the bypass flag is 0.
- R10: In a run where one instruction writes a register and the next four read it, the three that overlap the writer get the new value through R2, R3 and then the register file, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_i | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b_i | input | 5 | Second source register number of the execute-stage instruction |
| rf_a_i | input | 32 | Register file value for the first source |
| rf_b_i | input | 32 | Register file value for the second source |
| em_dst_i | input | 5 | Destination register in the execute/memory register |
| em_wen_i | input | 1 | Register write enable in the execute/memory register |
| em_val_i | input | 32 | ALU result in the execute/memory register |
| mw_dst_i | input | 5 | Destination register in the memory/writeback register |
| mw_wen_i | input | 1 | Register write enable in the memory/writeback register |
| mw_load_i | input | 1 | Memory/writeback instruction is a load |
| mw_val_i | input | 32 | Writeback value in the memory/writeback register |
| mem_store_i | input | 1 | Memory-stage instruction is a store |
| mem_sdreg_i | input | 5 | Data register number of the memory-stage store |
| mem_sdata_i | input | 32 | Store data carried in the execute/memory register |
| sel_a_o | output | 2 | First operand select: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b_o | output | 2 | Second operand select, same encoding |
| op_a_o | output | 32 | Selected first ALU operand |
| op_b_o | output | 32 | Selected second ALU operand |
| sdata_o | output | 32 | Store data delivered to the data memory |
| sdata_byp_o | output | 1 | Store data was taken from the memory/writeback load |

## Verification
The checks assume that the pipeline control upstream presents consistent stage contents: a load sitting in memory/writeback has its write enable set, and a register number carries meaning only in a stage that uses it. The checks make no assumption about which combinations of matches occur, so they hold for any register numbers. The stimulus keeps to this by building each case from small stage descriptions of real instruction sequences, including the dependent chain and the load-then-store pair. It also drives the corner cases where register zero or a cleared write enable sits next to a matching number.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int unsigned REG_AW = 5;
    localparam int unsigned XLEN   = 32;

    typedef enum logic [1:0] {
        SRC_RF = 2'b00,
        SRC_MW = 2'b01,
        SRC_EM = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic [REG_AW-1:0] dst;
        logic              wen;
    } producer_t;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          wen_i,
    output logic          hit_o
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit_o = wen_i && (dst_i != ZERO_REG) && (dst_i == src_i);
    end

endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
    import fwd_pkg::*;
#(
    parameter int unsigned AW = REG_AW,
    parameter int unsigned DW = XLEN
) (
    input  logic [AW-1:0] src_i,
    input  logic [DW-1:0] rf_val_i,
    input  logic [AW-1:0] em_dst_i,
    input  logic          em_wen_i,
    input  logic [DW-1:0] em_val_i,
    input  logic [AW-1:0] mw_dst_i,
    input  logic          mw_wen_i,
    input  logic [DW-1:0] mw_val_i,
    output logic [1:0]    sel_o,
    output logic [DW-1:0] val_o
);

    typedef struct packed {
        opnd_src_e     sel;
        logic [DW-1:0] val;
    } pick_t;

    logic  em_hit;
    logic  mw_hit;
    pick_t pick_d;

    fwd_hit #(.AW(AW)) u_em_hit (
        .src_i (src_i),
        .dst_i (em_dst_i),
        .wen_i (em_wen_i),
        .hit_o (em_hit)
    );

    fwd_hit #(.AW(AW)) u_mw_hit (
        .src_i (src_i),
        .dst_i (mw_dst_i),
        .wen_i (mw_wen_i),
        .hit_o (mw_hit)
    );

    always_comb begin
        pick_d.sel = SRC_RF;
        pick_d.val = rf_val_i;
        if (em_hit) begin
            pick_d.sel = SRC_EM;
            pick_d.val = em_val_i;
        end else if (mw_hit) begin
            pick_d.sel = SRC_MW;
            pick_d.val = mw_val_i;
        end
    end

    assign sel_o = pick_d.sel;
    assign val_o = pick_d.val;

endmodule

// File: rtl/fwd_store_bypass.sv
module fwd_store_bypass
    import fwd_pkg::*;
#(
    parameter int unsigned AW = REG_AW,
    parameter int unsigned DW = XLEN
) (
    input  logic          store_i,
    input  logic [AW-1:0] sdreg_i,
    input  logic [DW-1:0] sdata_i,
    input  logic [AW-1:0] mw_dst_i,
    input  logic          mw_wen_i,
    input  logic          mw_load_i,
    input  logic [DW-1:0] mw_val_i,
    output logic [DW-1:0] sdata_o,
    output logic          byp_o
);

    logic load_hit;

    fwd_hit #(.AW(AW)) u_ld_hit (
        .src_i (sdreg_i),
        .dst_i (mw_dst_i),
        .wen_i (mw_wen_i && mw_load_i),
        .hit_o (load_hit)
    );

    always_comb begin
        byp_o   = store_i && load_hit;
        sdata_o = byp_o ? mw_val_i : sdata_i;
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned AW = REG_AW,
    parameter int unsigned DW = XLEN
) (
    input  logic [AW-1:0] ex_src_a_i,
    input  logic [AW-1:0] ex_src_b_i,
    input  logic [DW-1:0] rf_a_i,
    input  logic [DW-1:0] rf_b_i,
    input  logic [AW-1:0] em_dst_i,
    input  logic          em_wen_i,
    input  logic [DW-1:0] em_val_i,
    input  logic [AW-1:0] mw_dst_i,
    input  logic          mw_wen_i,
    input  logic          mw_load_i,
    input  logic [DW-1:0] mw_val_i,
    input  logic          mem_store_i,
    input  logic [AW-1:0] mem_sdreg_i,
    input  logic [DW-1:0] mem_sdata_i,
    output logic [1:0]    sel_a_o,
    output logic [1:0]    sel_b_o,
    output logic [DW-1:0] op_a_o,
    output logic [DW-1:0] op_b_o,
    output logic [DW-1:0] sdata_o,
    output logic          sdata_byp_o
);

    localparam int unsigned NSRC = 2;

    logic [AW-1:0] src   [NSRC];
    logic [DW-1:0] rfv   [NSRC];
    logic [1:0]    sel   [NSRC];
    logic [DW-1:0] opv   [NSRC];

    assign src[0] = ex_src_a_i;
    assign src[1] = ex_src_b_i;
    assign rfv[0] = rf_a_i;
    assign rfv[1] = rf_b_i;

    for (genvar g = 0; g < NSRC; g++) begin : g_opnd
        fwd_operand #(.AW(AW), .DW(DW)) u_opnd (
            .src_i    (src[g]),
            .rf_val_i (rfv[g]),
            .em_dst_i (em_dst_i),
            .em_wen_i (em_wen_i),
            .em_val_i (em_val_i),
            .mw_dst_i (mw_dst_i),
            .mw_wen_i (mw_wen_i),
            .mw_val_i (mw_val_i),
            .sel_o    (sel[g]),
            .val_o    (opv[g])
        );
    end

    assign sel_a_o = sel[0];
    assign sel_b_o = sel[1];
    assign op_a_o  = opv[0];
    assign op_b_o  = opv[1];

    fwd_store_bypass #(.AW(AW), .DW(DW)) u_sbyp (
        .store_i   (mem_store_i),
        .sdreg_i   (mem_sdreg_i),
        .sdata_i   (mem_sdata_i),
        .mw_dst_i  (mw_dst_i),
        .mw_wen_i  (mw_wen_i),
        .mw_load_i (mw_load_i),
        .mw_val_i  (mw_val_i),
        .sdata_o   (sdata_o),
        .byp_o     (sdata_byp_o)
    );

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input logic [AW-1:0] ex_src_a_i,
    input logic [AW-1:0] em_dst_i,
    input logic          em_wen_i,
    input logic [DW-1:0] em_val_i,
    input logic [AW-1:0] mw_dst_i,
    input logic          mw_wen_i,
    input logic          mw_load_i,
    input logic [DW-1:0] mw_val_i,
    input logic          mem_store_i,
    input logic [AW-1:0] mem_sdreg_i,
    input logic [DW-1:0] mem_sdata_i,
    input logic [DW-1:0] rf_a_i,
    input logic [1:0]    sel_a_o,
    input logic [DW-1:0] op_a_o,
    input logic [DW-1:0] sdata_o,
    input logic          sdata_byp_o
);

    always_comb begin
        if (sel_a_o == 2'b10) begin
            p_em_value_r2: assert (op_a_o == em_val_i);
            p_em_needs_wen_r6: assert (em_wen_i && em_dst_i == ex_src_a_i);
            p_em_not_zero_r5: assert (em_dst_i != '0);
        end
        if (sel_a_o == 2'b01) begin
            p_mw_value_r3: assert (op_a_o == mw_val_i);
            p_mw_needs_wen_r6: assert (mw_wen_i && mw_dst_i == ex_src_a_i);
            p_mw_not_zero_r5: assert (mw_dst_i != '0);
            p_younger_wins_r4: assert (!(em_wen_i && em_dst_i == ex_src_a_i));
        end
        if (sel_a_o == 2'b00) begin
            p_rf_value_r1: assert (op_a_o == rf_a_i);
        end
        p_sel_code_legal_r1: assert (sel_a_o != 2'b11);
        if (sdata_byp_o) begin
            p_store_byp_r8: assert (mem_store_i && mw_load_i && mw_wen_i
                                    && mw_dst_i == mem_sdreg_i && mw_dst_i != '0
                                    && sdata_o == mw_val_i);
        end else begin
            p_store_pass_r9: assert (sdata_o == mem_sdata_i);
        end
    end

endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW), .DW(DW)) u_chk (
    .ex_src_a_i  (ex_src_a_i),
    .em_dst_i    (em_dst_i),
    .em_wen_i    (em_wen_i),
    .em_val_i    (em_val_i),
    .mw_dst_i    (mw_dst_i),
    .mw_wen_i    (mw_wen_i),
    .mw_load_i   (mw_load_i),
    .mw_val_i    (mw_val_i),
    .mem_store_i (mem_store_i),
    .mem_sdreg_i (mem_sdreg_i),
    .mem_sdata_i (mem_sdata_i),
    .rf_a_i      (rf_a_i),
    .sel_a_o     (sel_a_o),
    .op_a_o      (op_a_o),
    .sdata_o     (sdata_o),
    .sdata_byp_o (sdata_byp_o)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

    localparam int unsigned PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ex_src_a, ex_src_b, em_dst, mw_dst, mem_sdreg;
    logic        em_wen, mw_wen, mw_load, mem_store;
    logic [31:0] rf_a, rf_b, em_val, mw_val, mem_sdata;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] op_a, op_b, sdata;
    logic        sdata_byp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] regs [32];

    always #(PERIOD/2) clk = ~clk;

    fwd_unit uut (
        .ex_src_a_i (ex_src_a), .ex_src_b_i (ex_src_b),
        .rf_a_i (rf_a), .rf_b_i (rf_b),
        .em_dst_i (em_dst), .em_wen_i (em_wen), .em_val_i (em_val),
        .mw_dst_i (mw_dst), .mw_wen_i (mw_wen), .mw_load_i (mw_load), .mw_val_i (mw_val),
        .mem_store_i (mem_store), .mem_sdreg_i (mem_sdreg), .mem_sdata_i (mem_sdata),
        .sel_a_o (sel_a), .sel_b_o (sel_b), .op_a_o (op_a), .op_b_o (op_b),
        .sdata_o (sdata), .sdata_byp_o (sdata_byp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        ex_src_a = 5'd0; ex_src_b = 5'd0; em_dst = 5'd0; mw_dst = 5'd0; mem_sdreg = 5'd0;
        em_wen = 1'b0; mw_wen = 1'b0; mw_load = 1'b0; mem_store = 1'b0;
        rf_a = 32'h0; rf_b = 32'h0; em_val = 32'hE0E0_0001; mw_val = 32'hB0B0_0002;
        mem_sdata = 32'h5D5D_0003;
    endtask

    // drive on falling edge, sample a quarter period later
    task automatic settle();
        @(negedge clk);
        #(PERIOD/4);
    endtask

    task automatic t_reset_state();
        idle();
        settle();
        chk("R1 sel_a idle", {30'b0, sel_a}, 32'h0);
        chk("R1 sel_b idle", {30'b0, sel_b}, 32'h0);
        chk("R9 byp idle", {31'b0, sdata_byp}, 32'h0);
    endtask

    task automatic t_no_hazard();
        idle();
        ex_src_a = 5'd3; ex_src_b = 5'd4; rf_a = 32'h3333; rf_b = 32'h4444;
        em_dst = 5'd7; em_wen = 1'b1; mw_dst = 5'd8; mw_wen = 1'b1;
        settle();
        chk("R1 op_a from rf", op_a, 32'h3333);
        chk("R1 op_b from rf", op_b, 32'h4444);
        chk("R1 sel_a", {30'b0, sel_a}, 32'h0);
    endtask

    task automatic t_em_fwd();
        idle();
        ex_src_a = 5'd5; ex_src_b = 5'd6; rf_a = 32'h1; rf_b = 32'h2;
        em_dst = 5'd5; em_wen = 1'b1;
        settle();
        chk("R2 sel_a", {30'b0, sel_a}, 32'h2);
        chk("R2 op_a", op_a, 32'hE0E0_0001);
        chk("R7 op_b untouched", op_b, 32'h2);
    endtask

    task automatic t_mw_fwd();
        idle();
        ex_src_a = 5'd9; ex_src_b = 5'd9; rf_a = 32'h1; rf_b = 32'h1;
        mw_dst = 5'd9; mw_wen = 1'b1;
        settle();
        chk("R3 sel_a", {30'b0, sel_a}, 32'h1);
        chk("R3 op_b", op_b, 32'hB0B0_0002);
    endtask

    task automatic t_both_match();
        idle();
        ex_src_a = 5'd12; ex_src_b = 5'd13; rf_b = 32'h77;
        em_dst = 5'd12; em_wen = 1'b1; mw_dst = 5'd12; mw_wen = 1'b1;
        settle();
        chk("R4 sel_a younger", {30'b0, sel_a}, 32'h2);
        chk("R4 op_a younger", op_a, 32'hE0E0_0001);
    endtask

    task automatic t_split();
        idle();
        ex_src_a = 5'd14; ex_src_b = 5'd15;
        em_dst = 5'd15; em_wen = 1'b1; mw_dst = 5'd14; mw_wen = 1'b1;
        settle();
        chk("R7 sel_a mw", {30'b0, sel_a}, 32'h1);
        chk("R7 sel_b em", {30'b0, sel_b}, 32'h2);
    endtask

    task automatic t_zero_reg();
        idle();
        ex_src_a = 5'd0; ex_src_b = 5'd0; rf_a = 32'h0; rf_b = 32'h0;
        em_dst = 5'd0; em_wen = 1'b1; mw_dst = 5'd0; mw_wen = 1'b1;
        settle();
        chk("R5 op_a zero", op_a, 32'h0);
        chk("R5 sel_b rf", {30'b0, sel_b}, 32'h0);
    endtask

    task automatic t_wen_off();
        idle();
        ex_src_a = 5'd20; ex_src_b = 5'd20; rf_a = 32'hAA; rf_b = 32'hAA;
        em_dst = 5'd20; em_wen = 1'b0; mw_dst = 5'd20; mw_wen = 1'b0;
        settle();
        chk("R6 op_a rf", op_a, 32'hAA);
        chk("R6 sel_b rf", {30'b0, sel_b}, 32'h0);
        mw_wen = 1'b1;
        settle();
        chk("R6 em off, mw on", {30'b0, sel_a}, 32'h1);
    endtask

    // writer r1 followed by four readers; stage contents built per cycle
    task automatic t_chain();
        logic [31:0] newv;
        for (int i = 0; i < 32; i++) regs[i] = 32'h100 + i;
        regs[0] = 32'h0;
        newv = regs[2] + regs[3];
        // reader 1: writer in EX/MEM, rf still old
        idle();
        ex_src_a = 5'd1; ex_src_b = 5'd3; rf_a = regs[1]; rf_b = regs[3];
        em_dst = 5'd1; em_wen = 1'b1; em_val = newv;
        mw_dst = 5'd30; mw_wen = 1'b1; mw_val = 32'hDEAD;
        settle();
        chk("R10 reader1 via R2", op_a, newv);
        // reader 2: writer in MEM/WB
        idle();
        ex_src_a = 5'd1; ex_src_b = 5'd7; rf_a = regs[1]; rf_b = regs[7];
        em_dst = 5'd4; em_wen = 1'b1; em_val = 32'h4;
        mw_dst = 5'd1; mw_wen = 1'b1; mw_val = newv;
        settle();
        chk("R10 reader2 via R3", op_a, newv);
        // reader 3: writer has written; register file supplies it
        regs[1] = newv;
        idle();
        ex_src_a = 5'd9; ex_src_b = 5'd1; rf_a = regs[9]; rf_b = regs[1];
        em_dst = 5'd6; em_wen = 1'b1; mw_dst = 5'd4; mw_wen = 1'b1;
        settle();
        chk("R10 reader3 via rf", op_b, newv);
        chk("R10 reader3 sel_b", {30'b0, sel_b}, 32'h0);
    endtask

    task automatic t_store_bypass();
        idle();
        mem_store = 1'b1; mem_sdreg = 5'd4; mem_sdata = 32'h0000_0BAD;
        mw_dst = 5'd4; mw_wen = 1'b1; mw_load = 1'b1; mw_val = 32'h1234_5678;
        settle();
        chk("R8 store data", sdata, 32'h1234_5678);
        chk("R8 flag", {31'b0, sdata_byp}, 32'h1);
    endtask

    task automatic t_store_no_bypass();
        idle();
        mem_store = 1'b1; mem_sdreg = 5'd4; mem_sdata = 32'h0000_0C0D;
        mw_dst = 5'd4; mw_wen = 1'b1; mw_load = 1'b0; mw_val = 32'h9;
        settle();
        chk("R9 not a load", sdata, 32'h0000_0C0D);
        mw_load = 1'b1; mem_store = 1'b0;
        settle();
        chk("R9 not a store", {31'b0, sdata_byp}, 32'h0);
        mem_store = 1'b1; mw_dst = 5'd0; mem_sdreg = 5'd0;
        settle();
        chk("R9 zero reg", sdata, 32'h0000_0C0D);
        mw_dst = 5'd5; mem_sdreg = 5'd4;
        settle();
        chk("R9 other reg", sdata, 32'h0000_0C0D);
    endtask

    initial begin
        idle();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_no_hazard();
        t_em_fwd();
        t_mw_fwd();
        t_both_match();
        t_split();
        t_zero_reg();
        t_wen_off();
        t_chain();
        t_store_bypass();
        t_store_no_bypass();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule